// File: doc/BRIEF.md
# Guarded Multi-Output Clock Divider

This block derives several divided clock enables from one source clock. A single control word holds one 4-bit divide field for the core clock and one 4-bit field for each secondary clock. A field value f selects divide-by-(f+1). Each divider raises its enable for one source cycle in every divided period. Downstream logic gates its registers with these enables.

Software replaces the whole control word in one write over a plain write strobe and data bus. The current word is always visible on a read port. A write is checked before it is stored. It is dropped entirely if any secondary clock would run faster than the core clock, or more than eight times slower than it. It is also dropped whenever the low-power-run input is high. A status flag shows whether the most recent write was dropped.

At reset, a boot-option input selects the core divide value, either divide-by-1 or divide-by-8. A divider never switches to a new value in the middle of a period, so no runt pulse is produced.

Top module: `divclk_guard`

## Requirements
- R1: With rst_n low, the word reloads to core field bits [31:28] = 0111 when boot_lp is 1, or 0000 when boot_lp is 0. Bit 16 is 1 and every other bit is 0. wr_rejected reads 0.
- R2: rd_data always shows the stored word. Bits [15:0] always read 0, and write data on those bits has no effect. The word never changes in a cycle without wr_en.
- R3: The four divide fields sit at core [31:28], secondary 0 [27:24], secondary 1 [23:20] and secondary 2 [19:16]. A write with wr_en high and lp_run low stores all four fields in the same cycle when, for every secondary field s and core field c, s >= c and s+1 <= 8*(c+1).
- R4: A write that breaks the R3 rule for any secondary field is dropped as a whole, and the stored word keeps its old value.
- R5: A write presented while lp_run is high is dropped, and the stored word keeps its old value.
- R6: wr_rejected becomes 1 in the cycle after a dropped write (R4 or R5). It becomes 0 in the cycle after a stored write, and holds its value otherwise.
- R7: A divider whose field is f > 0 raises its enable for exactly one cycle every f+1 cycles.
- R8: A divider whose field is 0 holds its enable high in every cycle.
- R9: A divider loads a changed field only at the end of its current period. The first interval after a change keeps the old length, and later intervals use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock shared by all dividers |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_lp | input | 1 | Boot option: 1 selects a divide-by-8 core at reset |
| lp_run | input | 1 | Low-power-run mode; blocks all writes while high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | New control word |
| rd_data | output | 32 | Current control word |
| wr_rejected | output | 1 | Last write was dropped |
| core_en | output | 1 | Core clock enable |
| sec_en | output | 3 | Secondary clock enables, index k for secondary field k |

## Verification
The assertions assume that rst_n is held low for at least two source cycles. The first edge loads the reset word, and the second loads it into each divider. The bench always resets for three cycles. The assertions also assume that wr_en, wr_data and lp_run change only between clock edges. The bench drives every input on the falling edge. boot_lp is sampled only during reset, so the bench changes it only while rst_n is low.

// File: rtl/divclk_pkg.sv
package divclk_pkg;

    // Legal ratio between the core field and one secondary field (field = divide - 1)
    function automatic logic ratio_ok(input int unsigned core_f,
                                      input int unsigned sec_f,
                                      input int unsigned max_ratio);
        return (sec_f >= core_f) && ((sec_f + 1) <= max_ratio * (core_f + 1));
    endfunction

endpackage

// File: rtl/divclk_regfile.sv
module divclk_regfile
    import divclk_pkg::*;
#(
    parameter int NUM_SEC   = 3,
    parameter int FW        = 4,
    parameter int REG_W     = 32,
    parameter int MAX_RATIO = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_lp,
    input  logic             lp_run,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] cfg_q,
    output logic             rej_q
);
    localparam int LSB_USED = REG_W - FW * (NUM_SEC + 1);
    localparam logic [REG_W-1:0] USED_MASK =
        ~(((REG_W)'(1) << LSB_USED) - (REG_W)'(1));

    typedef struct packed {
        logic [REG_W-1:0] cfg;
        logic             rej;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    legal;
    logic [REG_W-1:0] rst_word;

    always_comb begin
        legal = 1'b1;
        for (int k = 0; k < NUM_SEC; k++) begin
            if (!ratio_ok(32'(wr_data[REG_W-1 -: FW]),
                          32'(wr_data[REG_W-1-FW*(k+1) -: FW]),
                          MAX_RATIO))
                legal = 1'b0;
        end

        rst_word = '0;
        rst_word[REG_W-1 -: FW] = boot_lp ? FW'(MAX_RATIO - 1) : '0;
        rst_word[LSB_USED] = 1'b1;

        st_d = st_q;
        if (!rst_n) begin
            st_d.cfg = rst_word;
            st_d.rej = 1'b0;
        end else if (wr_en) begin
            if (lp_run || !legal) begin
                st_d.rej = 1'b1;
            end else begin
                st_d.cfg = wr_data & USED_MASK;
                st_d.rej = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cfg_q = st_q.cfg;
    assign rej_q = st_q.rej;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lp_run) |=> ($stable(cfg_q) && rej_q));

    // R4
    drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rej_q) |-> $stable(cfg_q));

endmodule

// File: rtl/divclk_counter.sv
module divclk_counter #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] fld,
    output logic          en
);
    typedef struct packed {
        logic [FW-1:0] cnt;
        logic [FW-1:0] div;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    assign en = (st_q.cnt == st_q.div);

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.cnt = '0;
            st_d.div = fld;
        end else if (en) begin
            st_d.cnt = '0;
            st_d.div = fld;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R7
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (fld != '0)) |=> !en);

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.div);

    // R9
    mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.div));

endmodule

// File: rtl/divclk_guard.sv
module divclk_guard #(
    parameter int NUM_SEC   = 3,
    parameter int FW        = 4,
    parameter int REG_W     = 32,
    parameter int MAX_RATIO = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boot_lp,
    input  logic               lp_run,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    output logic               wr_rejected,
    output logic               core_en,
    output logic [NUM_SEC-1:0] sec_en
);
    logic [REG_W-1:0] cfg_q;

    divclk_regfile #(
        .NUM_SEC(NUM_SEC), .FW(FW), .REG_W(REG_W), .MAX_RATIO(MAX_RATIO)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .boot_lp(boot_lp), .lp_run(lp_run),
        .wr_en(wr_en), .wr_data(wr_data), .cfg_q(cfg_q), .rej_q(wr_rejected)
    );

    divclk_counter #(.FW(FW)) u_core (
        .clk(clk), .rst_n(rst_n), .fld(cfg_q[REG_W-1 -: FW]), .en(core_en)
    );

    for (genvar k = 0; k < NUM_SEC; k++) begin : g_sec
        divclk_counter #(.FW(FW)) u_sec (
            .clk(clk), .rst_n(rst_n),
            .fld(cfg_q[REG_W-1-FW*(k+1) -: FW]), .en(sec_en[k])
        );
    end

    assign rd_data = cfg_q;

    // R2
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-FW*(NUM_SEC+1)-1:0] == '0);

endmodule

// File: tb/divclk_guard_test.sv
module divclk_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    localparam logic [31:0] VEC_WD [NV] = '{
        32'h07770000, 32'h08000000, 32'h1F330000, 32'h10110000,
        32'h2258FFFF, 32'hFFFE0000, 32'hFFFF0000, 32'h22580000};
    localparam logic [31:0] VEC_RD [NV] = '{
        32'h07770000, 32'h07770000, 32'h1F330000, 32'h1F330000,
        32'h22580000, 32'h22580000, 32'hFFFF0000, 32'h22580000};
    localparam logic [NV-1:0] VEC_REJ = 8'b0010_1010; // bit i = vector i

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_lp = 1'b0;
    logic        lp_run = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        wr_rejected;
    logic        core_en;
    logic [2:0]  sec_en;

    int n_chk = 0;
    int n_bad = 0;

    divclk_guard uut (
        .clk(clk), .rst_n(rst_n), .boot_lp(boot_lp), .lp_run(lp_run),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .wr_rejected(wr_rejected), .core_en(core_en), .sec_en(sec_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic en_of(input int i);
        return (i == 0) ? core_en : sec_en[i-1];
    endfunction

    task automatic do_reset(input logic boot);
        @(negedge clk);
        rst_n = 1'b0;
        boot_lp = boot;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [31:0] d, input logic lp);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; lp_run = lp;
        @(negedge clk);
        wr_en = 1'b0; lp_run = 1'b0;
    endtask

    task automatic wait_pulse(input int i);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!en_of(i) && guard < 64);
    endtask

    task automatic measure(input int i, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!en_of(i) && n < 64);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int p;
        logic all_hi;

        // R1: reset with boot option low
        do_reset(1'b0);
        @(negedge clk);
        check("R1 reset word", rd_data, 32'h00010000);
        check("R1 reset flag", {31'b0, wr_rejected}, 32'h0);

        // Vector walk: R3 legal stores, R4 ratio drops, R2 low bits, R6 flag
        for (int v = 0; v < NV; v++) begin
            do_write(VEC_WD[v], 1'b0);
            check("R3/R4 word", rd_data, VEC_RD[v]);
            check("R6 flag", {31'b0, wr_rejected}, {31'b0, VEC_REJ[v]});
        end

        // R7: periods with word 2258 -> 3,3,6,9
        wait_pulse(0); measure(0, p); check("R7 core period", p, 3);
        wait_pulse(1); measure(1, p); check("R7 sec0 period", p, 3);
        wait_pulse(2); measure(2, p); check("R7 sec1 period", p, 6);
        wait_pulse(3); measure(3, p); check("R7 sec2 period", p, 9);

        // R9: change sec2 from divide-by-9 to divide-by-3 right after a pulse
        wait_pulse(3);
        wr_en = 1'b1; wr_data = 32'h22220000;
        p = 0;
        do begin
            @(negedge clk);
            wr_en = 1'b0;
            p++;
        end while (!sec_en[2] && p < 64);
        check("R9 old interval kept", p, 9);
        measure(3, p);
        check("R9 new interval", p, 3);

        // R5: legal write ignored under low-power run
        do_write(32'h00010000, 1'b1);
        check("R5 locked word", rd_data, 32'h22220000);
        check("R6 flag after lock", {31'b0, wr_rejected}, 32'h1);

        // R2: word holds with no write
        repeat (5) @(negedge clk);
        check("R2 idle hold", rd_data, 32'h22220000);

        // R3/R8: all divide-by-1
        do_write(32'h00000000, 1'b0);
        check("R3 all ones word", rd_data, 32'h00000000);
        check("R6 flag clears", {31'b0, wr_rejected}, 32'h0);
        wait_pulse(0);
        all_hi = 1'b1;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (!(core_en && (&sec_en))) all_hi = 1'b0;
        end
        check("R8 enables stay high", {31'b0, all_hi}, 32'h1);

        // R1: reset with boot option high, core divide-by-8
        do_reset(1'b1);
        @(negedge clk);
        check("R1 boot word", rd_data, 32'h70010000);
        check("R1 boot flag", {31'b0, wr_rejected}, 32'h0);
        wait_pulse(0); measure(0, p); check("R7 boot core period", p, 8);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule